// File: doc/BRIEF.md
# RF Front-End Serial Control Slave

This block is the slave side of a two-wire control bus with a clock line and a bidirectional data line, used to program an RF switch. It watches both lines with an internal system clock. It detects the sequence start condition and collects a command frame. It answers when the frame carries its own slave ID, a programmable group ID or the broadcast ID. Three sequences are handled: a register write with one data frame, a register read where the slave returns one data frame and then parks the bus, and a short write that places seven data bits into register 0. Register 0 is presented on `reg0_o` and drives the switch path selection.

The slave ID is fixed by two select pins. Malformed or illegal accesses are not simply dropped. Each kind is recorded in its own sticky bit of a status register. Software reads that register to learn what went wrong, and the read clears it. Writing a one to its top bit returns every register to its default.

Top module: `rffe_slave`

## Requirements
- R1: The slave ID is {2'b10, ssel_i}, so ssel_i = 2'b00, 2'b01, 2'b10, 2'b11 give 4'b1000, 4'b1001, 4'b1010, 4'b1011. Address 0x1F reads back {2'b00, 2'b01, slave ID}.
- R2: A sequence starts when SDATA rises and then falls while SCLK stays low. Bits are sampled on SCLK falling edges, MSB first. The command frame is 4 ID bits, then 8 command bits, then an odd-parity bit. Frames clocked without a start condition are ignored.
- R3: The command 3'b010 followed by a 5-bit address, then a data frame of 8 bits plus odd parity, writes the byte. Register 0 (address 0x00) is visible on reg0_o and resets to 0x00.
- R4: A command whose MSB is 1 writes {1'b0, cmd[6:0]} into register 0.
- R5: The command 3'b011 followed by a 5-bit address starts a read. After the command, one SCLK cycle is left to the bus park. On the next 9 rising edges the slave launches 8 data bits MSB first and then odd parity. On the following rising edge it drives 0, and after that cycle's falling edge it releases sdata_oe_o.
- R6: A command frame with wrong parity is discarded and sets status bit 6.
- R7: A write data frame with wrong parity is discarded and sets status bit 3.
- R8: The known addresses are 0x00, 0x1A, 0x1B, 0x1D, 0x1E and 0x1F. A write to any other address changes nothing and sets status bit 1. A read from any other address returns 0x00 and sets status bit 2.
- R9: The broadcast ID 4'b0000 and the group ID accept writes. The group ID is held in bits 3:0 of address 0x1B, which is writable, reads as {4'b0000, group ID} and resets to 0. A read sent to either of these IDs leaves SDATA undriven and sets status bit 0.
- R10: A sequence sent to any other ID changes no register.
- R11: A start condition that arrives during the data frame of a write discards the write and sets status bit 5.
- R12: Status (0x1A) reads as {1'b0, sticky bits 6:0}, and the read clears the sticky bits. Writing a byte with bit 7 set resets all registers to their defaults. Status bit 4 is never set.
- R13: Address 0x1D reads 0xD0 and address 0x1E reads 0x1A. Writes to these addresses and to 0x1F have no effect and set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Bus clock from the master |
| sdata_i | input | 1 | Bus data as seen on the line |
| ssel_i | input | 2 | Slave ID select pins, {SSEL1, SSEL2} |
| sdata_o | output | 1 | Data driven by the slave during a read |
| sdata_oe_o | output | 1 | Output enable for sdata_o |
| reg0_o | output | 8 | Switch control register 0 |

## Verification
The assertions assume that each SCLK phase lasts longer than the synchronizer latency plus one system clock. They also assume that the master changes SDATA only together with an SCLK rising edge, except inside a start condition. Under those assumptions every launched bit settles while SCLK is high, and the park bit is the last value before release. The stimulus holds each SCLK phase for four system clocks. It switches SDATA only on the cycle that raises SCLK, or inside the start task while SCLK is low, and it never drives the line while the slave owns it.

// File: rtl/rffe_pkg.sv
package rffe_pkg;
  localparam int SID_W     = 4;
  localparam int CMD_W     = 8;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int CMD_BITS  = SID_W + CMD_W + 1;
  localparam int DATA_BITS = DATA_W + 1;
  localparam int STS_W     = 7;

  localparam logic [ADDR_W-1:0] A_REG0  = 5'h00;
  localparam logic [ADDR_W-1:0] A_STS   = 5'h1A;
  localparam logic [ADDR_W-1:0] A_GSID  = 5'h1B;
  localparam logic [ADDR_W-1:0] A_PROD  = 5'h1D;
  localparam logic [ADDR_W-1:0] A_MANUF = 5'h1E;
  localparam logic [ADDR_W-1:0] A_USID  = 5'h1F;

  // status bit positions
  localparam int S_SWRST = 7;
  localparam int S_CPAR  = 6;
  localparam int S_LEN   = 5;
  localparam int S_DPAR  = 3;
  localparam int S_RDUN  = 2;
  localparam int S_WRUN  = 1;
  localparam int S_BGID  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WDATA, ST_RPARK, ST_RDATA, ST_REND
  } seq_state_e;

  function automatic logic addr_known(input logic [ADDR_W-1:0] a);
    return a inside {A_REG0, A_STS, A_GSID, A_PROD, A_MANUF, A_USID};
  endfunction
endpackage

// File: rtl/rffe_edge.sv
module rffe_edge #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= {q[STAGES-1:0], in_i[g]};
    end
    assign lvl_o[g]  = q[STAGES-1];
    assign rise_o[g] = q[STAGES-1] & ~q[STAGES];
    assign fall_o[g] = ~q[STAGES-1] & q[STAGES];
  end
endmodule

// File: rtl/rffe_regs.sv
module rffe_regs
  import rffe_pkg::*;
#(
  parameter logic [DATA_W-1:0] PROD_ID  = 8'hD0,
  parameter logic [DATA_W-1:0] MANUF_ID = 8'h1A,
  parameter logic [1:0]        MANUF_HI = 2'b01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SID_W-1:0]  usid_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STS_W-1:0]  err_set_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] reg0_o,
  output logic [SID_W-1:0]  gsid_o
);
  logic [STS_W-1:0] sts_q;
  logic             swrst;

  assign swrst = we_i && addr_i == A_STS && wdata_i[S_SWRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg0_o <= '0;
      gsid_o <= '0;
      sts_q  <= '0;
    end else if (swrst) begin
      reg0_o <= '0;
      gsid_o <= '0;
      sts_q  <= '0;
    end else begin
      if (we_i && addr_i == A_REG0) reg0_o <= wdata_i;
      if (we_i && addr_i == A_GSID) gsid_o <= wdata_i[SID_W-1:0];
      sts_q <= ((re_i && addr_i == A_STS) ? '0 : sts_q) | err_set_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_REG0:  rdata_o = reg0_o;
      A_STS:   rdata_o = {1'b0, sts_q};
      A_GSID:  rdata_o = {{(DATA_W-SID_W){1'b0}}, gsid_o};
      A_PROD:  rdata_o = PROD_ID;
      A_MANUF: rdata_o = MANUF_ID;
      A_USID:  rdata_o = {2'b00, MANUF_HI, usid_i};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rffe_fsm.sv
module rffe_fsm
  import rffe_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_lvl_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              sdat_lvl_i,
  input  logic              sdat_rise_i,
  input  logic              sdat_fall_i,
  input  logic [SID_W-1:0]  usid_i,
  input  logic [SID_W-1:0]  gsid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [STS_W-1:0]  err_o,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int CNT_W = $clog2(CMD_BITS + 1);

  seq_state_e          state, state_n;
  logic [CNT_W-1:0]    cnt, cnt_n;
  logic [CMD_BITS-1:0] sh, sh_n, frame;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic                armed, armed_n, sdo_n, oe_n;
  logic                rd_phase, ssc;
  logic [SID_W-1:0]    sid;
  logic [CMD_W-1:0]    cmd;
  logic                hit_own, hit_any;

  assign frame   = {sh[CMD_BITS-2:0], sdat_lvl_i};
  assign sid     = frame[CMD_BITS-1 -: SID_W];
  assign cmd     = frame[CMD_W:1];
  assign hit_own = sid == usid_i;
  assign hit_any = hit_own || sid == gsid_i || sid == '0;
  assign addr_o  = (state == ST_CMD) ? A_REG0 : addr_q;

  always_comb begin
    state_n = state; cnt_n = cnt; sh_n = sh; addr_n = addr_q;
    armed_n = armed; sdo_n = sdo_o; oe_n = oe_o;
    we_o = 1'b0; re_o = 1'b0; wdata_o = '0; err_o = '0;
    rd_phase = state inside {ST_RPARK, ST_RDATA, ST_REND};
    ssc = sdat_fall_i && !sclk_lvl_i && armed && !rd_phase;
    if (sclk_rise_i) armed_n = 1'b0;
    else if (sdat_rise_i && !sclk_lvl_i && !rd_phase) armed_n = 1'b1;
    if (ssc) begin
      armed_n = 1'b0;
      if (state == ST_WDATA) err_o[S_LEN] = 1'b1;
      state_n = ST_CMD;
      cnt_n   = '0;
    end else begin
      unique case (state)
        ST_CMD: if (sclk_fall_i) begin
          sh_n  = frame;
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(CMD_BITS - 1)) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            if (hit_any) begin
              if (!(^frame)) err_o[S_CPAR] = 1'b1;
              else if (cmd[CMD_W-1]) begin
                we_o    = 1'b1;
                wdata_o = {1'b0, cmd[CMD_W-2:0]};
              end else if (cmd[CMD_W-1 -: 3] == 3'b010) begin
                addr_n  = cmd[ADDR_W-1:0];
                state_n = ST_WDATA;
              end else if (cmd[CMD_W-1 -: 3] == 3'b011) begin
                if (!hit_own) err_o[S_BGID] = 1'b1;
                else begin
                  addr_n  = cmd[ADDR_W-1:0];
                  state_n = ST_RPARK;
                end
              end
            end
          end
        end
        ST_WDATA: if (sclk_fall_i) begin
          sh_n  = frame;
          cnt_n = cnt + 1'b1;
          if (cnt == CNT_W'(DATA_BITS - 1)) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
            if (!(^frame[DATA_BITS-1:0])) err_o[S_DPAR] = 1'b1;
            else if (!addr_known(addr_q)) err_o[S_WRUN] = 1'b1;
            else begin
              we_o    = 1'b1;
              wdata_o = frame[DATA_W:1];
            end
          end
        end
        ST_RPARK: if (sclk_rise_i) begin
          sh_n = '0;
          sh_n[DATA_BITS-1:0] = {rdata_i, ~^rdata_i};
          re_o    = 1'b1;
          cnt_n   = '0;
          state_n = ST_RDATA;
          if (!addr_known(addr_q)) err_o[S_RDUN] = 1'b1;
        end
        ST_RDATA: if (sclk_rise_i) begin
          oe_n = 1'b1;
          if (cnt == CNT_W'(DATA_BITS)) begin
            sdo_n   = 1'b0;  // bus park bit
            state_n = ST_REND;
          end else begin
            sdo_n = sh[DATA_BITS-1];
            sh_n  = sh << 1;
            cnt_n = cnt + 1'b1;
          end
        end
        ST_REND: if (sclk_fall_i) begin
          oe_n    = 1'b0;
          state_n = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; addr_q <= '0;
      armed <= 1'b0; sdo_o <= 1'b0; oe_o <= 1'b0;
    end else begin
      state <= state_n; cnt <= cnt_n; sh <= sh_n; addr_q <= addr_n;
      armed <= armed_n; sdo_o <= sdo_n; oe_o <= oe_n;
    end
  end
endmodule

// File: rtl/rffe_slave.sv
module rffe_slave
  import rffe_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] PROD_ID     = 8'hD0,
  parameter logic [DATA_W-1:0] MANUF_ID    = 8'h1A,
  parameter logic [1:0]        MANUF_HI    = 2'b01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        ssel_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic [DATA_W-1:0] reg0_o
);
  logic [1:0]        lvl, rise, fall;
  logic              sclk_lvl;
  logic [SID_W-1:0]  usid, gsid;
  logic              we, re;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic [STS_W-1:0]  err_set;

  assign usid     = {2'b10, ssel_i};
  assign sclk_lvl = lvl[0];

  rffe_edge #(.N(2), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .in_i({sdata_i, sclk_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  rffe_fsm u_fsm (
    .clk_i, .rst_ni,
    .sclk_lvl_i(lvl[0]), .sclk_rise_i(rise[0]), .sclk_fall_i(fall[0]),
    .sdat_lvl_i(lvl[1]), .sdat_rise_i(rise[1]), .sdat_fall_i(fall[1]),
    .usid_i(usid), .gsid_i(gsid), .rdata_i(rdata),
    .we_o(we), .re_o(re), .addr_o(addr), .wdata_o(wdata), .err_o(err_set),
    .sdo_o(sdata_o), .oe_o(sdata_oe_o)
  );

  rffe_regs #(.PROD_ID(PROD_ID), .MANUF_ID(MANUF_ID), .MANUF_HI(MANUF_HI)) u_regs (
    .clk_i, .rst_ni, .usid_i(usid), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .err_set_i(err_set), .rdata_o(rdata), .reg0_o(reg0_o),
    .gsid_o(gsid)
  );
endmodule

// File: rtl/rffe_slave_chk.sv
module rffe_slave_chk
  import rffe_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sdata_o,
  input logic              sdata_oe_o,
  input logic [DATA_W-1:0] reg0_o,
  input logic              sclk_lvl,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              swrst_bit,
  input logic [STS_W-1:0]  err_set
);
  assert_park_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sdata_oe_o) |-> !$past(sdata_o));

  assert_launch_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> sclk_lvl);

  assert_cmd_par_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set[S_CPAR] |-> !we);

  assert_dat_par_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set[S_DPAR] |-> !we);

  assert_reg0_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reg0_o) |-> $past(we && (addr == A_REG0 || (addr == A_STS && swrst_bit))));

  assert_one_err_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(err_set));
endmodule

bind rffe_slave rffe_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
  .reg0_o(reg0_o), .sclk_lvl(sclk_lvl), .we(we), .addr(addr),
  .swrst_bit(wdata[rffe_pkg::S_SWRST]), .err_set(err_set)
);

// File: tb/sim_rffe_slave.sv
module sim_rffe_slave;
  localparam int HP = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sclk = 1'b0, m_sdata = 1'b0;
  logic [1:0] ssel = 2'b00;
  logic       dut_sdo, dut_oe, bus;
  logic [7:0] reg0;
  int         n_vec = 0, n_bad = 0;

  logic [8:0] exp_q[$], act_q[$];
  string      tag_q[$];

  assign bus = dut_oe ? dut_sdo : m_sdata;

  rffe_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(bus), .ssel_i(ssel),
    .sdata_o(dut_sdo), .sdata_oe_o(dut_oe), .reg0_o(reg0)
  );

  always #10 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0 && act_q.size() > 0) begin
      logic [8:0] e, a;
      string t;
      e = exp_q.pop_front(); a = act_q.pop_front(); t = tag_q.pop_front();
      chk({23'd0, a}, {23'd0, e}, t);
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    m_sdata = b; sclk = 1'b1; hold(HP);
    sclk = 1'b0; hold(HP);
  endtask

  task automatic ssc();
    m_sdata = 1'b0; hold(HP);
    m_sdata = 1'b1; hold(HP);
    m_sdata = 1'b0; hold(HP);
  endtask

  task automatic send_cmd(input logic [3:0] sid, input logic [7:0] cmd, input logic bad);
    logic [11:0] f;
    f = {sid, cmd};
    for (int i = 11; i >= 0; i--) clk_bit(f[i]);
    clk_bit((~^f) ^ bad);
  endtask

  task automatic send_data(input logic [7:0] d, input logic bad);
    for (int i = 7; i >= 0; i--) clk_bit(d[i]);
    clk_bit((~^d) ^ bad);
  endtask

  task automatic wr(input logic [3:0] sid, input logic [4:0] a, input logic [7:0] d,
                    input logic bad_d);
    ssc();
    send_cmd(sid, {3'b010, a}, 1'b0);
    send_data(d, bad_d);
    hold(HP);
  endtask

  task automatic r0wr(input logic [3:0] sid, input logic [6:0] d);
    ssc();
    send_cmd(sid, {1'b1, d}, 1'b0);
    hold(HP);
  endtask

  // read with scoreboard; bus park cycles checked inline (R5)
  task automatic rd(input logic [3:0] sid, input logic [4:0] a, input logic [7:0] e,
                    input string tag);
    logic [8:0] got;
    ssc();
    send_cmd(sid, {3'b011, a}, 1'b0);
    exp_q.push_back({e, ~^e}); tag_q.push_back(tag);
    m_sdata = 1'b0;
    sclk = 1'b1; hold(HP); sclk = 1'b0; hold(HP);
    got = '0;
    for (int i = 0; i < 9; i++) begin
      sclk = 1'b1; hold(HP);
      got = {got[7:0], bus};
      sclk = 1'b0; hold(HP);
    end
    sclk = 1'b1; hold(HP);
    chk({30'd0, dut_oe, dut_sdo}, 32'h2, "R5 park drive");
    sclk = 1'b0; hold(HP);
    chk({31'd0, dut_oe}, 32'h0, "R5 park release");
    act_q.push_back(got);
    hold(HP);
  endtask

  // read that must get no reply (R9)
  task automatic rd_none(input logic [3:0] sid, input logic [4:0] a, input string tag);
    logic seen;
    seen = 1'b0;
    ssc();
    send_cmd(sid, {3'b011, a}, 1'b0);
    m_sdata = 1'b0;
    for (int i = 0; i < 11; i++) begin
      sclk = 1'b1; hold(HP); seen |= dut_oe;
      sclk = 1'b0; hold(HP); seen |= dut_oe;
    end
    chk({31'd0, seen}, 32'h0, tag);
    hold(HP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected end of run");
    finish_run();
  end

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(2);
    chk({24'd0, reg0}, 32'h00, "R3 reset reg0");
    chk({31'd0, dut_oe}, 32'h0, "R5 reset oe");

    // R13 read-only IDs, R1 slave ID 4'b1000
    rd(4'b1000, 5'h1D, 8'hD0, "R13 prod");
    rd(4'b1000, 5'h1E, 8'h1A, "R13 manuf");
    rd(4'b1000, 5'h1F, 8'h18, "R1 usid 00");

    // R3 register write and readback
    wr(4'b1000, 5'h00, 8'hA5, 1'b0);
    chk({24'd0, reg0}, 32'hA5, "R3 write");
    rd(4'b1000, 5'h00, 8'hA5, "R3 readback");

    // R4 register-0 write
    r0wr(4'b1000, 7'h55);
    chk({24'd0, reg0}, 32'h55, "R4 reg0 short write");
    r0wr(4'b1000, 7'h7F);
    chk({24'd0, reg0}, 32'h7F, "R4 bit7 cleared");
    wr(4'b1000, 5'h00, 8'h55, 1'b0);

    // R10 foreign ID
    wr(4'b1001, 5'h00, 8'h11, 1'b0);
    chk({24'd0, reg0}, 32'h55, "R10 foreign id");

    // R2 frames without start condition are ignored
    send_cmd(4'b1000, {3'b010, 5'h00}, 1'b0);
    send_data(8'hEE, 1'b0);
    hold(HP);
    chk({24'd0, reg0}, 32'h55, "R2 no start");

    // R1 select pins 11
    ssel = 2'b11;
    hold(4);
    rd(4'b1011, 5'h1F, 8'h1B, "R1 usid 11");
    wr(4'b1011, 5'h00, 8'h3C, 1'b0);
    chk({24'd0, reg0}, 32'h3C, "R1 write new id");
    wr(4'b1000, 5'h00, 8'h01, 1'b0);
    chk({24'd0, reg0}, 32'h3C, "R10 old id");

    // R9 broadcast and group
    wr(4'b0000, 5'h00, 8'h42, 1'b0);
    chk({24'd0, reg0}, 32'h42, "R9 broadcast write");
    wr(4'b1011, 5'h1B, 8'hF7, 1'b0);
    rd(4'b1011, 5'h1B, 8'h07, "R9 group reg");
    wr(4'b0111, 5'h00, 8'h24, 1'b0);
    chk({24'd0, reg0}, 32'h24, "R9 group write");
    rd_none(4'b0111, 5'h00, "R9 group read undriven");
    rd_none(4'b0000, 5'h00, "R9 broadcast read undriven");
    rd(4'b1011, 5'h1A, 8'h01, "R9 status bit0");
    rd(4'b1011, 5'h1A, 8'h00, "R12 clear on read");

    // R6 command parity
    ssc();
    send_cmd(4'b1011, {3'b010, 5'h00}, 1'b1);
    send_data(8'h99, 1'b0);
    hold(HP);
    chk({24'd0, reg0}, 32'h24, "R6 discard");
    rd(4'b1011, 5'h1A, 8'h40, "R6 status bit6");

    // R7 data parity
    wr(4'b1011, 5'h00, 8'h66, 1'b1);
    chk({24'd0, reg0}, 32'h24, "R7 discard");
    rd(4'b1011, 5'h1A, 8'h08, "R7 status bit3");

    // R8 unused addresses
    wr(4'b1011, 5'h05, 8'h12, 1'b0);
    rd(4'b1011, 5'h1A, 8'h02, "R8 write unused");
    rd(4'b1011, 5'h07, 8'h00, "R8 read unused data");
    rd(4'b1011, 5'h1A, 8'h04, "R8 read unused flag");

    // R11 start during data frame
    ssc();
    send_cmd(4'b1011, {3'b010, 5'h00}, 1'b0);
    clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b1);
    rd(4'b1011, 5'h1A, 8'h20, "R11 length flag");
    chk({24'd0, reg0}, 32'h24, "R11 discard");

    // R13 writes to read-only
    wr(4'b1011, 5'h1D, 8'h00, 1'b0);
    wr(4'b1011, 5'h1F, 8'h00, 1'b0);
    rd(4'b1011, 5'h1D, 8'hD0, "R13 ro write");
    rd(4'b1011, 5'h1A, 8'h00, "R13 no flag");

    // R12 software reset
    wr(4'b1011, 5'h1A, 8'h7F, 1'b0);
    chk({24'd0, reg0}, 32'h24, "R12 no reset without bit7");
    wr(4'b1011, 5'h1A, 8'h80, 1'b0);
    chk({24'd0, reg0}, 32'h00, "R12 soft reset reg0");
    rd(4'b1011, 5'h1B, 8'h00, "R12 soft reset group");

    hold(20);
    chk(exp_q.size(), 0, "R5 scoreboard drained");
    finish_run();
  end
endmodule